// File: doc/BRIEF.md
# Two-Port Banked Cache Access Steering

This block sits between two cache request sources and a data array split into four single-ported banks. Each cycle it may take one request from each of its two request ports. The bank a request needs comes from the two address bits just above the 64-byte line offset. Consecutive lines therefore fall in different banks. When the two requests need different banks, both go to the array in the same cycle. When they need the same bank, one goes and the other waits one cycle in a single hold register.

The bank storage is modelled inside the block as four one-port arrays. Each array holds one data word per line and has a read latency of one cycle. Every accepted request, read or write, produces exactly one response. The response comes back on the port that sent the request and carries that request's tag. Responses on each port keep the order in which that port's requests were accepted.

With addresses spread evenly, two requests land in the same bank one time in four. The hold register keeps the cost of such a collision to a single stall cycle. An alternating winner rule keeps either port from being starved when collisions repeat.

Top module: `dbank_arbiter`

## Requirements
- R1: A request's bank is address bits [7:6] and its row within the bank is bits [ADDR_W-1:8]. Bits [5:0] are ignored. A write stores data that a later read of the same line returns, from either port.
- R2: If both ports are accepted in one cycle and their bank bits differ, both are issued that cycle, and both `rsp_valid_o` bits are high one cycle later.
- R3: If both ports are accepted in one cycle with equal bank bits, exactly one request is issued. The other is held and issued on the next cycle, so its response comes one cycle after the winner's.
- R4: On a collision, port 0 wins unless port 0 also won the previous collision, in which case port 1 wins. After reset, the first collision is won by port 0.
- R5: `req_ready_o` is 2'b11 whenever nothing is held. It is 2'b00 in the cycle that holds a losing request, and no request is accepted in that cycle. A handshake is valid and ready high in the same cycle.
- R6: A response appears exactly one cycle after its request is issued, on the same port, with the request's tag. A read returns the stored word. A write returns the data it wrote.
- R7: During and right after reset, `rsp_valid_o` is 0, `req_ready_o` is 2'b11 and no bank is enabled.
- R8: `bank_en_o[b]` is high exactly in a cycle when a request is issued to bank b. `bank_we_o[b]` is high when that request is a write. No bank receives more than one command per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 2 | Request present, one bit per port |
| req_ready_o | output | 2 | Request can be taken, one bit per port |
| req_we_i | input | 2 | 1 = write, 0 = read, per port |
| req_addr_i | input | 2 x ADDR_W | Byte address per port |
| req_wdata_i | input | 2 x DATA_W | Write data per port |
| req_tag_i | input | 2 x TAG_W | Tag returned with the response |
| bank_en_o | output | NBANK | Bank command issued this cycle |
| bank_we_o | output | NBANK | Issued bank command is a write |
| rsp_valid_o | output | 2 | Response present, per port |
| rsp_tag_o | output | 2 x TAG_W | Tag of the response |
| rsp_data_o | output | 2 x DATA_W | Read data, or the written data for a write |

## Verification
The hardest state to reach is a run of collisions that are not interleaved with plain traffic. The alternating winner only shows when one collision follows another, and the held request must drain before the next pair can enter. Directed sequences therefore pair same-bank requests on both ports, then send idle cycles to let the held entry drain, three times in a row. The expected winners are port 0, then port 1, then port 0. A long random phase with addresses spread over all banks then produces collisions about a quarter of the time. In that phase collisions mix with reads, writes, ready-low cycles and partly idle ports.

// File: rtl/dbank_pkg.sv
package dbank_pkg;
    localparam int unsigned DBANK_PORTS = 2;

    // Identity of a request port, also used to remember a collision winner
    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_e;
endpackage

// File: rtl/dbank_ram.sv
module dbank_ram #(
    parameter int ROW_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Single port, write-first, one cycle latency
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[row] <= wdata;
                rdata    <= wdata;
            end else begin
                rdata    <= mem[row];
            end
        end
    end
endmodule

// File: rtl/dbank_pick.sv
module dbank_pick
    import dbank_pkg::*;
#(
    parameter int BSEL_W = 2
) (
    input  logic [1:0]             cand_v,
    input  logic [1:0][BSEL_W-1:0] cand_bank,
    input  port_e                  last_win,
    output logic [1:0]             grant,
    output logic                   conflict,
    output port_e                  winner
);
    always_comb begin
        conflict = (&cand_v) && (cand_bank[0] == cand_bank[1]);
        winner   = (last_win == PORT_A) ? PORT_B : PORT_A;
        if (conflict) begin
            grant = (winner == PORT_A) ? 2'b01 : 2'b10;
        end else begin
            grant = cand_v;
        end
    end
endmodule

// File: rtl/dbank_arbiter.sv
module dbank_arbiter
    import dbank_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 4,
    parameter int NBANK      = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             req_valid_i,
    output logic [1:0]             req_ready_o,
    input  logic [1:0]             req_we_i,
    input  logic [1:0][ADDR_W-1:0] req_addr_i,
    input  logic [1:0][DATA_W-1:0] req_wdata_i,
    input  logic [1:0][TAG_W-1:0]  req_tag_i,
    output logic [NBANK-1:0]       bank_en_o,
    output logic [NBANK-1:0]       bank_we_o,
    output logic [1:0]             rsp_valid_o,
    output logic [1:0][TAG_W-1:0]  rsp_tag_o,
    output logic [1:0][DATA_W-1:0] rsp_data_o
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(NBANK);
    localparam int ROW_W  = ADDR_W - OFS_W - BSEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  tag;
    } req_t;

    typedef struct packed {
        logic                   hold_v;
        logic                   hold_port;
        req_t                   hold;
        port_e                  last_win;
        logic [1:0]             rsp_v;
        logic [1:0][TAG_W-1:0]  rsp_tag;
        logic [1:0][BSEL_W-1:0] rsp_bank;
    } state_t;

    state_t st_d, st_q;

    req_t [1:0]             cand_w;
    logic [1:0]             cand_v_w;
    logic [1:0][BSEL_W-1:0] cand_bank_w;
    logic [1:0]             grant_w;
    logic                   conflict_w;
    port_e                  winner_w;
    logic                   lose_idx_w;

    logic [NBANK-1:0][ROW_W-1:0]  bk_row;
    logic [NBANK-1:0][DATA_W-1:0] bk_wdata;
    logic [NBANK-1:0][DATA_W-1:0] bank_rdata;

    // Line offset bits do not take part in steering
    logic unused_ofs;
    assign unused_ofs = ^{req_addr_i[0][OFS_W-1:0], req_addr_i[1][OFS_W-1:0]};

    // Candidates: the held request alone, or the two incoming ones
    always_comb begin
        req_ready_o = {2{~st_q.hold_v}};
        for (int p = 0; p < 2; p++) begin
            if (st_q.hold_v) begin
                cand_v_w[p] = (st_q.hold_port == p[0]);
                cand_w[p]   = st_q.hold;
            end else begin
                cand_v_w[p] = req_valid_i[p];
                cand_w[p]   = '{addr: req_addr_i[p], we: req_we_i[p],
                                wdata: req_wdata_i[p], tag: req_tag_i[p]};
            end
            cand_bank_w[p] = cand_w[p].addr[OFS_W +: BSEL_W];
        end
    end

    dbank_pick #(.BSEL_W(BSEL_W)) u_pick (
        .cand_v    (cand_v_w),
        .cand_bank (cand_bank_w),
        .last_win  (st_q.last_win),
        .grant     (grant_w),
        .conflict  (conflict_w),
        .winner    (winner_w)
    );

    assign lose_idx_w = (winner_w == PORT_A);

    // Bank command steering
    always_comb begin
        bank_en_o = '0;
        bank_we_o = '0;
        bk_row    = '0;
        bk_wdata  = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int p = 0; p < 2; p++) begin
                if (grant_w[p] && (cand_bank_w[p] == BSEL_W'(b))) begin
                    bank_en_o[b] = 1'b1;
                    bank_we_o[b] = cand_w[p].we;
                    bk_row[b]    = cand_w[p].addr[OFS_W+BSEL_W +: ROW_W];
                    bk_wdata[b]  = cand_w[p].wdata;
                end
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dbank_ram #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_ram (
            .clk   (clk),
            .en    (bank_en_o[b]),
            .we    (bank_we_o[b]),
            .row   (bk_row[b]),
            .wdata (bk_wdata[b]),
            .rdata (bank_rdata[b])
        );
    end

    // Next state
    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = grant_w;
        for (int p = 0; p < 2; p++) begin
            if (grant_w[p]) begin
                st_d.rsp_tag[p]  = cand_w[p].tag;
                st_d.rsp_bank[p] = cand_bank_w[p];
            end
        end
        st_d.hold_v = conflict_w;
        if (conflict_w) begin
            st_d.hold_port = lose_idx_w;
            st_d.hold      = cand_w[lose_idx_w];
            st_d.last_win  = winner_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.last_win <= PORT_B;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rsp_valid_o = st_q.rsp_v;
        rsp_tag_o   = st_q.rsp_tag;
        for (int p = 0; p < 2; p++) begin
            rsp_data_o[p] = bank_rdata[st_q.rsp_bank[p]];
        end
    end
endmodule

// File: rtl/dbank_arbiter_chk.sv
module dbank_arbiter_chk #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 6,
    parameter int BSEL_W = 2,
    parameter int NBANK  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             req_valid_i,
    input logic [1:0]             req_ready_o,
    input logic [1:0][ADDR_W-1:0] req_addr_i,
    input logic [1:0]             rsp_valid_o,
    input logic [NBANK-1:0]       bank_en_o,
    input logic [1:0]             grant_w,
    input logic                   conflict_w
);
    logic [BSEL_W-1:0] bk0, bk1;
    logic              both_in;
    logic              seen_win_q;

    assign bk0     = req_addr_i[0][OFS_W +: BSEL_W];
    assign bk1     = req_addr_i[1][OFS_W +: BSEL_W];
    assign both_in = (req_valid_i == 2'b11) && (req_ready_o == 2'b11);

    // Checker's own record of the last collision winner, from the grants
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_win_q <= 1'b1;
        else if (conflict_w) seen_win_q <= grant_w[1];
    end

    assert_pair_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (both_in && bk0 != bk1) |=> (rsp_valid_o == 2'b11));

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (both_in && bk0 == bk1) |-> ($countones(grant_w) == 1));

    assert_hold_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_w |=> ($countones(grant_w) == 1));

    assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_w |-> (grant_w == (seen_win_q ? 2'b01 : 2'b10)));

    assert_ready_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (both_in && bk0 == bk1) |=> (req_ready_o == 2'b00));

    assert_resp_p0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_w[0] |=> rsp_valid_o[0]);

    assert_resp_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_w[1] |=> rsp_valid_o[1]);

    assert_bank_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_en_o) == $countones(grant_w));
endmodule

bind dbank_arbiter dbank_arbiter_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .BSEL_W (BSEL_W),
    .NBANK  (NBANK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .bank_en_o   (bank_en_o),
    .grant_w     (grant_w),
    .conflict_w  (conflict_w)
);

// File: tb/dbank_arbiter_test.sv
`timescale 1ns/1ps
module dbank_arbiter_test;
    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        req_valid_i, req_ready_o, req_we_i;
    logic [1:0][11:0]  req_addr_i;
    logic [1:0][31:0]  req_wdata_i;
    logic [1:0][3:0]   req_tag_i;
    logic [3:0]        bank_en_o, bank_we_o;
    logic [1:0]        rsp_valid_o;
    logic [1:0][3:0]   rsp_tag_o;
    logic [1:0][31:0]  rsp_data_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbank_arbiter uut (.*);

    // Reference state
    logic [31:0] mdl_mem [64];
    logic        m_hv, m_hp, m_last;
    logic [11:0] m_ha;
    logic        m_hwe;
    logic [31:0] m_hd;
    logic [3:0]  m_ht;
    logic [1:0]  exp_rv;
    logic [3:0]  exp_tag [2];
    logic [31:0] exp_data [2];

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One cycle of the reference, applied to the inputs now on the pins
    task automatic model_step();
        logic [1:0]  cv, g;
        logic [11:0] ca [2];
        logic        cwe [2];
        logic [31:0] cd [2];
        logic [3:0]  ct [2];
        logic        conf, win;
        logic [3:0]  een, ewe;
        for (int p = 0; p < 2; p++) begin
            if (m_hv) begin
                cv[p] = (m_hp == p[0]);
                ca[p] = m_ha; cwe[p] = m_hwe; cd[p] = m_hd; ct[p] = m_ht;
            end else begin
                cv[p] = req_valid_i[p];
                ca[p] = req_addr_i[p]; cwe[p] = req_we_i[p];
                cd[p] = req_wdata_i[p]; ct[p] = req_tag_i[p];
            end
        end
        conf = (cv == 2'b11) && (ca[0][7:6] == ca[1][7:6]);
        win  = (m_last == 1'b0) ? 1'b1 : 1'b0;
        g    = conf ? (win ? 2'b10 : 2'b01) : cv;
        een = '0; ewe = '0;
        for (int p = 0; p < 2; p++) begin
            if (g[p]) begin
                een[ca[p][7:6]] = 1'b1;
                ewe[ca[p][7:6]] = cwe[p];
                exp_tag[p]  = ct[p];
                exp_data[p] = cwe[p] ? cd[p] : mdl_mem[ca[p][11:6]];
                if (cwe[p]) mdl_mem[ca[p][11:6]] = cd[p];
            end
        end
        exp_rv = g;
        check(bank_en_o == een, "R8 bank_en_o", 64'(bank_en_o), 64'(een));
        check(bank_we_o == ewe, "R8 bank_we_o", 64'(bank_we_o), 64'(ewe));
        if (conf) begin
            m_hv = 1'b1; m_hp = ~win; m_last = win;
            m_ha = ca[~win]; m_hwe = cwe[~win]; m_hd = cd[~win]; m_ht = ct[~win];
        end else begin
            m_hv = 1'b0;
        end
    endtask

    task automatic check_outputs();
        check(req_ready_o == {2{~m_hv}}, "R5 req_ready_o",
              64'(req_ready_o), 64'({2{~m_hv}}));
        check(rsp_valid_o == exp_rv, "R2/R3 rsp_valid_o",
              64'(rsp_valid_o), 64'(exp_rv));
        for (int p = 0; p < 2; p++) begin
            if (exp_rv[p] && rsp_valid_o[p]) begin
                check(rsp_tag_o[p] == exp_tag[p], "R6 rsp_tag_o",
                      64'(rsp_tag_o[p]), 64'(exp_tag[p]));
                check(rsp_data_o[p] == exp_data[p], "R6/R1 rsp_data_o",
                      64'(rsp_data_o[p]), 64'(exp_data[p]));
            end
        end
    endtask

    // Inputs already driven after a falling edge; finish the cycle
    task automatic tick();
        #1;
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic drive(input logic [1:0] v, input logic [1:0] we,
                         input logic [11:0] a0, input logic [11:0] a1,
                         input logic [31:0] d0, input logic [31:0] d1);
        req_valid_i    = v;
        req_we_i       = we;
        req_addr_i[0]  = a0;
        req_addr_i[1]  = a1;
        req_wdata_i[0] = d0;
        req_wdata_i[1] = d1;
        req_tag_i[0]   = 4'($urandom);
        req_tag_i[1]   = 4'($urandom);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 1'b0;
        drive(2'b00, 2'b00, 12'h0, 12'h0, 32'h0, 32'h0);
        m_hv = 0; m_hp = 0; m_last = 1; exp_rv = 2'b00;
        m_ha = '0; m_hwe = 0; m_hd = '0; m_ht = '0;
        repeat (3) @(negedge clk);
        check(rsp_valid_o == 2'b00, "R7 rsp_valid_o in reset", 64'(rsp_valid_o), 64'h0);
        check(req_ready_o == 2'b11, "R7 req_ready_o in reset", 64'(req_ready_o), 64'h3);
        check(bank_en_o == 4'h0, "R7 bank_en_o in reset", 64'(bank_en_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid_o == 2'b00, "R7 rsp_valid_o after reset", 64'(rsp_valid_o), 64'h0);

        // Fill every line; adjacent lines sit in different banks (R2)
        for (int i = 0; i < 32; i++) begin
            drive(2'b11, 2'b11,
                  {6'(2 * i), 6'($urandom)}, {6'(2 * i + 1), 6'($urandom)},
                  $urandom, $urandom);
            tick();
            check(rsp_valid_o == 2'b11, "R2 both issue on distinct banks",
                  64'(rsp_valid_o), 64'h3);
        end

        // R1: write on port 0, read the same line back on port 1
        drive(2'b01, 2'b01, 12'hA40, 12'h0, 32'hCAFE_0001, 32'h0);
        tick();
        drive(2'b10, 2'b00, 12'h0, 12'hA7F, 32'h0, 32'h0);
        tick();
        check(rsp_data_o[1] == 32'hCAFE_0001, "R1 read back across ports",
              64'(rsp_data_o[1]), 64'hCAFE_0001);

        // R3/R4/R5: three collisions in a row
        for (int k = 0; k < 3; k++) begin
            drive(2'b11, 2'b00, 12'h0C0, 12'h4C5, 32'h0, 32'h0);
            tick();
            check(rsp_valid_o == ((k == 1) ? 2'b10 : 2'b01), "R4 collision winner",
                  64'(rsp_valid_o), (k == 1) ? 64'h2 : 64'h1);
            check(req_ready_o == 2'b00, "R5 ready low while holding",
                  64'(req_ready_o), 64'h0);
            drive(2'b11, 2'b00, 12'h000, 12'h040, 32'h0, 32'h0);
            tick();
            check(rsp_valid_o == ((k == 1) ? 2'b01 : 2'b10), "R3 held request drains",
                  64'(rsp_valid_o), (k == 1) ? 64'h1 : 64'h2);
        end
        drive(2'b00, 2'b00, 12'h0, 12'h0, 32'h0, 32'h0);
        tick();
        check(rsp_valid_o == 2'b00, "R5 input while holding was not taken",
              64'(rsp_valid_o), 64'h0);

        // Random traffic: reads, writes, collisions, idle ports
        for (int i = 0; i < 4000; i++) begin
            drive(2'($urandom), 2'($urandom), 12'($urandom), 12'($urandom),
                  $urandom, $urandom);
            tick();
        end
        drive(2'b00, 2'b00, 12'h0, 12'h0, 32'h0, 32'h0);
        tick();
        tick();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule